// File: doc/BRIEF.md
# External Sync Arm and Trigger Controller

This block decides when sample data may start moving from the application side of a DAC transport path toward the link. It also decides when the tone generators and pseudo-random pattern generators are restarted. Single-cycle command pulses from a control register stage can arm the controller, disarm it, ask for an immediate software sync, or ask for a manual sync request. A manual sync request leaves the block on an output port, so fabric logic can route it back as the external sync source.

Once armed, the controller raises a waiting flag and holds every per-channel valid output low. It then waits for a rising edge on the external sync input, which runs on the DAC clock. When that edge arrives, the controller emits a single-cycle sync/restart pulse, drops the waiting flag and opens the valid gate. A build option removes external sync support. In that build, the arm, disarm, manual-request and sync-input pins have no effect, and only the software sync command produces a restart pulse.

Top module: `dac_sync_trigger`

## Requirements
- R1: While reset is asserted and right after it is released, `wait_trig_o` is 0, every bit of `lane_valid_o` is 1, and `sync_rst_o` and `man_req_o` are 0.
- R2: With external sync enabled, an arm pulse in one cycle makes `wait_trig_o` 1 from the next cycle. For as long as `wait_trig_o` is 1, every bit of `lane_valid_o` is 0; in every other state every bit is 1.
- R3: While waiting, suppose `ext_sync_i` is sampled 0 at one rising clock edge and 1 at the next, with no disarm pulse at that next edge. Then, in the cycle after that next edge, `sync_rst_o` is 1 for exactly one cycle, `wait_trig_o` is 0 and the valid outputs are 1. An arm pulse in that same cycle keeps the controller armed.
- R4: Only a low-to-high transition triggers. A sync input that is already high when arming, or that stays high, leaves the controller waiting with no pulse until the input goes low and then high again.
- R5: A disarm pulse returns the controller to idle from the next cycle without any sync pulse. If arm and disarm arrive together, the disarm takes effect.
- R6: A software sync pulse produces a one-cycle `sync_rst_o` pulse in the following cycle, in both build variants, and does not change the waiting state.
- R7: With external sync enabled, a manual request pulse appears on `man_req_o` one cycle later for one cycle. With external sync disabled, `man_req_o` stays 0.
- R8: With external sync disabled (`EXT_SYNC_EN` = 0), the arm, disarm and sync-input pins are ignored: `wait_trig_o` stays 0, the valid outputs stay 1, and no pulse appears except from software sync.
- R9: A rising edge on `ext_sync_i` while the controller is idle produces no sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_pulse_i | input | 1 | Arm command, one-cycle pulse |
| disarm_pulse_i | input | 1 | Disarm command, one-cycle pulse |
| sw_sync_pulse_i | input | 1 | Software sync command, one-cycle pulse |
| man_req_pulse_i | input | 1 | Manual sync request command, one-cycle pulse |
| ext_sync_i | input | 1 | External sync level, synchronous to clk |
| man_req_o | output | 1 | Registered manual sync request toward fabric |
| sync_rst_o | output | 1 | One-cycle restart pulse for tone and pattern generators |
| wait_trig_o | output | 1 | High while armed and not yet triggered |
| lane_valid_o | output | NUM_CH | Per-channel valid toward the link, gated while waiting |

## Verification
The properties assume that `ext_sync_i` is already synchronous to `clk` and settles before each rising edge, so that a clean edge is visible as a low sample followed by a high sample. They place no limit on how commands overlap: arm, disarm, software sync and a sync edge may all fall in the same cycle. The stimulus changes every input on the falling clock edge. Directed sequences cover each overlap that matters. Random cycles toggle the sync input often enough that edges land both while armed and while idle, and command pulses come in at mixed rates.

// File: rtl/dac_sync_trigger_pkg.sv
package dac_sync_trigger_pkg;
   typedef enum logic [0:0] {
      ARM_IDLE = 1'b0,
      ARM_WAIT = 1'b1
   } arm_state_e;

   localparam int unsigned MAX_CH = 64;
endpackage

// File: rtl/dst_rise_det.sv
module dst_rise_det #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] rise
);
   logic [W-1:0] din_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) din_q <= '0;
      else        din_q <= din;
   end

   assign rise = din & ~din_q;
endmodule

// File: rtl/dst_arm_fsm.sv
module dst_arm_fsm
   import dac_sync_trigger_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic disarm,
   input  logic rise,
   output logic waiting,
   output logic trig
);
   arm_state_e state_q, state_d;

   assign trig = (state_q == ARM_WAIT) && rise && !disarm;

   always_comb begin
      state_d = state_q;
      if (disarm)    state_d = ARM_IDLE;
      else if (arm)  state_d = ARM_WAIT;
      else if (trig) state_d = ARM_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARM_IDLE;
      else        state_q <= state_d;
   end

   assign waiting = (state_q == ARM_WAIT);
endmodule

// File: rtl/dst_valid_gate.sv
module dst_valid_gate #(
   parameter int unsigned NUM_CH = 2
) (
   input  logic              hold,
   output logic [NUM_CH-1:0] valid
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign valid[ch] = ~hold;
   end
endmodule

// File: rtl/dst_pulse_reg.sv
module dst_pulse_reg #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/dac_sync_trigger.sv
module dac_sync_trigger
   import dac_sync_trigger_pkg::*;
#(
   parameter bit          EXT_SYNC_EN = 1'b1,
   parameter int unsigned NUM_CH      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_pulse_i,
   input  logic              disarm_pulse_i,
   input  logic              sw_sync_pulse_i,
   input  logic              man_req_pulse_i,
   input  logic              ext_sync_i,
   output logic              man_req_o,
   output logic              sync_rst_o,
   output logic              wait_trig_o,
   output logic [NUM_CH-1:0] lane_valid_o
);
   localparam int unsigned PW = 2;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_num_ch
      $error("dac_sync_trigger: NUM_CH out of range");
   end

   logic          trig;
   logic          waiting;
   logic          man_gated;
   logic [PW-1:0] pulse_d;
   logic [PW-1:0] pulse_q;

   if (EXT_SYNC_EN) begin : g_ext
      logic rise;

      dst_rise_det #(.W(1)) u_rise (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (ext_sync_i),
         .rise (rise)
      );

      dst_arm_fsm u_fsm (
         .clk    (clk),
         .rst_n  (rst_n),
         .arm    (arm_pulse_i),
         .disarm (disarm_pulse_i),
         .rise   (rise),
         .waiting(waiting),
         .trig   (trig)
      );

      assign man_gated = man_req_pulse_i;
   end else begin : g_sw_only
      logic unused_ext_pins;
      assign unused_ext_pins = ^{arm_pulse_i, disarm_pulse_i, man_req_pulse_i, ext_sync_i};
      assign trig      = 1'b0;
      assign waiting   = 1'b0;
      assign man_gated = 1'b0;
   end

   assign pulse_d = {man_gated, trig | sw_sync_pulse_i};

   dst_pulse_reg #(.W(PW)) u_pulse (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pulse_d),
      .q    (pulse_q)
   );

   dst_valid_gate #(.NUM_CH(NUM_CH)) u_gate (
      .hold (waiting),
      .valid(lane_valid_o)
   );

   assign sync_rst_o  = pulse_q[0];
   assign man_req_o   = pulse_q[1];
   assign wait_trig_o = waiting;
endmodule

// File: rtl/dac_sync_trigger_chk.sv
module dac_sync_trigger_chk #(
   parameter bit          EXT_SYNC_EN = 1'b1,
   parameter int unsigned NUM_CH      = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm_pulse_i,
   input logic              disarm_pulse_i,
   input logic              sw_sync_pulse_i,
   input logic              man_req_pulse_i,
   input logic              ext_sync_i,
   input logic              man_req_o,
   input logic              sync_rst_o,
   input logic              wait_trig_o,
   input logic [NUM_CH-1:0] lane_valid_o
);
   logic ext_prev;
   logic rise_c;
   logic cause_q;

   assign rise_c = ext_sync_i & ~ext_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_prev <= 1'b0;
         cause_q  <= 1'b0;
      end else begin
         ext_prev <= ext_sync_i;
         cause_q  <= sw_sync_pulse_i | (wait_trig_o & rise_c & ~disarm_pulse_i);
      end
   end

   AST_ARM_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_SYNC_EN && arm_pulse_i && !disarm_pulse_i) |=> wait_trig_o); // R2
   AST_WAIT_GATES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      wait_trig_o |-> (lane_valid_o == '0)); // R2
   AST_IDLE_VALID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !wait_trig_o |-> (&lane_valid_o)); // R2
   AST_EDGE_TRIGGERS: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_trig_o && rise_c && !disarm_pulse_i && !arm_pulse_i) |=> (sync_rst_o && !wait_trig_o)); // R3
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_rst_o && !sw_sync_pulse_i && !(wait_trig_o && rise_c)) |=> !sync_rst_o); // R3
   AST_NO_EDGE_KEEPS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_trig_o && !rise_c && !disarm_pulse_i) |=> wait_trig_o); // R4
   AST_DISARM_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      disarm_pulse_i |=> !wait_trig_o); // R5
   AST_SW_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_sync_pulse_i |=> sync_rst_o); // R6
   AST_MANUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_SYNC_EN && man_req_pulse_i) |=> man_req_o); // R7
   AST_SW_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !EXT_SYNC_EN |-> (!wait_trig_o && !man_req_o)); // R8
   AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_rst_o |-> cause_q); // R9
endmodule

bind dac_sync_trigger dac_sync_trigger_chk #(
   .EXT_SYNC_EN(EXT_SYNC_EN),
   .NUM_CH     (NUM_CH)
) u_chk (.*);

// File: tb/dac_sync_trigger_tb_top.sv
`timescale 1ns/1ps
module dac_sync_trigger_tb_top;
   localparam int unsigned NCH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm_p = 1'b0, disarm_p = 1'b0, sw_p = 1'b0, man_p = 1'b0, xs = 1'b0;

   logic           e_man, e_pulse, e_wait;
   logic [NCH-1:0] e_valid;
   logic           n_man, n_pulse, n_wait;
   logic [NCH-1:0] n_valid;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   logic m_wait = 1'b0;
   logic m_q    = 1'b0;

   always #5 clk = ~clk;

   dac_sync_trigger #(.EXT_SYNC_EN(1'b1), .NUM_CH(NCH)) dut_i (
      .clk(clk), .rst_n(rst_n), .arm_pulse_i(arm_p), .disarm_pulse_i(disarm_p),
      .sw_sync_pulse_i(sw_p), .man_req_pulse_i(man_p), .ext_sync_i(xs),
      .man_req_o(e_man), .sync_rst_o(e_pulse), .wait_trig_o(e_wait), .lane_valid_o(e_valid));

   dac_sync_trigger #(.EXT_SYNC_EN(1'b0), .NUM_CH(NCH)) dut_nx_i (
      .clk(clk), .rst_n(rst_n), .arm_pulse_i(arm_p), .disarm_pulse_i(disarm_p),
      .sw_sync_pulse_i(sw_p), .man_req_pulse_i(man_p), .ext_sync_i(xs),
      .man_req_o(n_man), .sync_rst_o(n_pulse), .wait_trig_o(n_wait), .lane_valid_o(n_valid));

   function automatic logic [NCH-1:0] exp_valid(input logic waiting);
      return waiting ? '0 : '1;
   endfunction

   function automatic logic exp_next_wait(input logic cur, input logic rise, input logic a, input logic d);
      if (d) return 1'b0;
      if (a) return 1'b1;
      if (cur && rise) return 1'b0;
      return cur;
   endfunction

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   task automatic step(input logic a, input logic d, input logic s, input logic m,
                       input logic x, input string tag);
      logic rise, trig, nw;
      arm_p = a; disarm_p = d; sw_p = s; man_p = m; xs = x;
      rise = x && !m_q;
      trig = m_wait && rise && !d;
      nw   = exp_next_wait(m_wait, rise, a, d);
      @(posedge clk);
      @(negedge clk);
      m_wait = nw;
      m_q    = x;
      chk({tag, " wait_trig_o"}, 64'(e_wait), 64'(nw));
      chk({tag, " lane_valid_o"}, 64'(e_valid), 64'(exp_valid(nw)));
      chk({tag, " sync_rst_o"}, 64'(e_pulse), 64'(trig || s));
      chk({tag, " man_req_o"}, 64'(e_man), 64'(m));
      chk({tag, " R8 sw-only wait"}, 64'(n_wait), 64'(0));
      chk({tag, " R8 sw-only valid"}, 64'(n_valid), 64'(exp_valid(1'b0)));
      chk({tag, " R8/R6 sw-only pulse"}, 64'(n_pulse), 64'(s));
      chk({tag, " R7 sw-only man_req_o"}, 64'(n_man), 64'(0));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      // R1: values during reset
      chk("R1 wait in reset", 64'(e_wait), 64'(0));
      chk("R1 pulse in reset", 64'(e_pulse), 64'(0));
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1 wait after reset", 64'(e_wait), 64'(0));
      chk("R1 valid after reset", 64'(e_valid), 64'(exp_valid(1'b0)));
      chk("R1 pulse after reset", 64'(e_pulse), 64'(0));
      chk("R1 man after reset", 64'(e_man), 64'(0));

      // R9: edges while idle do nothing
      step(0, 0, 0, 0, 1, "R9");
      step(0, 0, 0, 0, 0, "R9");
      step(0, 0, 0, 0, 1, "R9");
      step(0, 0, 0, 0, 0, "R9");

      // R2 then R3: arm, clean edge, single pulse
      step(1, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 1, "R3");
      step(0, 0, 0, 0, 1, "R3");
      step(0, 0, 0, 0, 0, "R3");

      // R4: already high at arm time
      step(0, 0, 0, 0, 1, "R4");
      step(1, 0, 0, 0, 1, "R4");
      step(0, 0, 0, 0, 1, "R4");
      step(0, 0, 0, 0, 1, "R4");
      step(0, 0, 0, 0, 0, "R4");
      step(0, 0, 0, 0, 1, "R4");
      step(0, 0, 0, 0, 0, "R4");

      // R5: disarm, and disarm beating arm; disarm on the edge cycle
      step(1, 0, 0, 0, 0, "R5");
      step(0, 1, 0, 0, 0, "R5");
      step(0, 0, 0, 0, 1, "R5");
      step(0, 0, 0, 0, 0, "R5");
      step(1, 1, 0, 0, 0, "R5");
      step(1, 0, 0, 0, 0, "R5");
      step(0, 1, 0, 0, 1, "R5");
      step(0, 0, 0, 0, 0, "R5");

      // R3: arm again in the trigger cycle stays armed
      step(1, 0, 0, 0, 0, "R3");
      step(1, 0, 0, 0, 1, "R3");
      step(0, 0, 0, 0, 0, "R3");
      step(0, 0, 0, 0, 1, "R3");
      step(0, 0, 0, 0, 0, "R3");

      // R6: software sync idle and while armed
      step(0, 0, 1, 0, 0, "R6");
      step(1, 0, 0, 0, 0, "R6");
      step(0, 0, 1, 0, 0, "R6");
      step(0, 1, 0, 0, 0, "R6");

      // R7: manual request
      step(0, 0, 0, 1, 0, "R7");
      step(0, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 1, 0, "R7");
      step(0, 0, 0, 1, 0, "R7");
      step(0, 0, 0, 0, 0, "R7");

      // R8 plus R2/R3: constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic a, d, s, m, x;
         a = ($urandom_range(0, 99) < 12);
         d = ($urandom_range(0, 99) < 5);
         s = ($urandom_range(0, 99) < 5);
         m = ($urandom_range(0, 99) < 6);
         x = ($urandom_range(0, 9) < 3) ? ~xs : xs;
         step(a, d, s, m, x, "RND R2/R3/R8");
      end
      step(0, 0, 0, 0, 0, "RND R2/R3/R8");
      summary();
   end
endmodule